// File: doc/BRIEF.md
# Configuration Reboot Command Sequencer

This block makes an FPGA restart itself from a chosen location in serial flash. On a start pulse it takes a 24-bit flash address and an 8-bit flash read opcode. It then sends a fixed 20-byte packet, one byte at a time, to the device's internal 8-bit configuration port. The packet tells the configuration logic where to fetch the next bitstream and then orders a warm reboot. The address and opcode bytes go into fixed slots inside an otherwise constant packet.

The port takes each byte with its bit order reversed, so the block mirrors every byte on its way out. Each byte is handed over with a one-clock write strobe, and only after the port has signalled ready. While the packet is in flight, `busy_o` is high. When the last byte has gone, a one-cycle `done_o` pulse follows.

The control is a four-state machine:

- `ST_IDLE`: waits for a start pulse. A start pulse moves it to `ST_WAIT` and captures the address and opcode.
- `ST_WAIT`: holds the current byte until ready is sampled high, then moves to `ST_STROBE`.
- `ST_STROBE`: asserts the write strobe for one clock. It then returns to `ST_WAIT` with the next byte index, or moves to `ST_DONE` after byte 19.
- `ST_DONE`: raises the done pulse, then returns to `ST_IDLE` unconditionally.

Top module: `cfg_reboot_seq`

## Requirements
- R1: After reset, `port_wr_o`, `busy_o` and `done_o` are low.
- R2: A start pulse sampled while the block is idle (`busy_o` and `done_o` both low) makes `busy_o` high from the following cycle until the final byte has been written.
- R3: Each sequence writes exactly 20 bytes. Every write strobe lasts one clock, and strobes are never asserted in two consecutive cycles.
- R4: Before mirroring, the constant bytes are, by position counted from 0:
  - 0 and 1: 0xFF
  - 2 and 3: 0xAA, 0x99
  - 4 and 5: 0x32, 0x61
  - 8 and 9: 0x32, 0x81
  - 12 and 13: 0x30, 0xA1
  - 14 and 15: 0x00, 0x0E
  - 16 to 19: 0x20, 0x00, 0x20, 0x00
- R5: Before mirroring, the variable bytes are placed as follows: position 6 is address bits [15:8], position 7 is address bits [7:0], position 10 is the read opcode, and position 11 is address bits [23:16].
- R6: Every byte is bit-reversed on the port: `port_data_o[k]` equals bit 7-k of the packet byte.
- R7: A write strobe is asserted only in a cycle after `port_ready_i` was sampled high. While ready stays low, no byte is written and `busy_o` stays high.
- R8: The address and opcode are captured on the accepted start pulse. Changes to those inputs during the sequence do not alter the bytes sent.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The running packet is unchanged and only one done pulse results.
- R10: The cycle after the last write strobe, `done_o` is high for exactly one cycle and `busy_o` is low. Both are low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| flash_addr_i | input | 24 | Flash address of the bitstream to load |
| read_op_i | input | 8 | Flash read opcode (commonly 0x03) |
| port_ready_i | input | 1 | Configuration port can accept a byte |
| port_data_o | output | 8 | Bit-reversed packet byte |
| port_wr_o | output | 1 | One-clock write strobe for port_data_o |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the final byte |

## Verification
The assertions watch the handshake on every cycle:
- the strobe follows a sampled ready and never repeats in the next cycle;
- the strobe occurs only while busy;
- done is a single-cycle pulse, is clear of busy, and follows a strobe;
- an idle start raises busy;
- the captured address and opcode stay stable while busy.

The packet content can only be shown by the bench's scenarios. These scenarios cover:
- the 20-byte order and the mirrored bit order;
- where the address and opcode land in the packet;
- immunity to input changes and to a second start;
- behaviour under ready stalls of varying length.

// File: rtl/cfg_reboot_pkg.sv
package cfg_reboot_pkg;

    // Byte width of the configuration port and of every packet element.
    localparam int BYTE_W  = 8;
    // Flash address width carried by the packet.
    localparam int ADDR_W  = 24;
    // Number of bytes in one reboot packet.
    localparam int PKT_LEN = 20;
    localparam int IDX_W   = $clog2(PKT_LEN);

    // Constant packet bytes, unmirrored.
    localparam logic [BYTE_W-1:0] B_DUMMY    = 8'hFF;
    localparam logic [BYTE_W-1:0] B_SYNC_HI  = 8'hAA;
    localparam logic [BYTE_W-1:0] B_SYNC_LO  = 8'h99;
    localparam logic [BYTE_W-1:0] B_HDR_GEN  = 8'h32;
    localparam logic [BYTE_W-1:0] B_HDR_G1   = 8'h61;
    localparam logic [BYTE_W-1:0] B_HDR_G2   = 8'h81;
    localparam logic [BYTE_W-1:0] B_HDR_CMD  = 8'h30;
    localparam logic [BYTE_W-1:0] B_HDR_CMDL = 8'hA1;
    localparam logic [BYTE_W-1:0] B_REBOOT   = 8'h0E;
    localparam logic [BYTE_W-1:0] B_NOOP     = 8'h20;
    localparam logic [BYTE_W-1:0] B_ZERO     = 8'h00;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_STROBE = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_t;

endpackage

// File: rtl/cfg_bit_mirror.sv
module cfg_bit_mirror #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // End-for-end reversal: input bit k lands on output bit W-1-k.
    for (genvar k = 0; k < W; k++) begin : g_bit
        assign dout[k] = din[W-1-k];
    end

endmodule

// File: rtl/cfg_pkt_rom.sv
module cfg_pkt_rom
    import cfg_reboot_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] op_i,
    output logic [BYTE_W-1:0] byte_o
);

    // Packet assembly: constant framing with address and opcode spliced in.
    always_comb begin
        unique case (int'(idx_i))
            0, 1:    byte_o = B_DUMMY;
            2:       byte_o = B_SYNC_HI;
            3:       byte_o = B_SYNC_LO;
            4:       byte_o = B_HDR_GEN;
            5:       byte_o = B_HDR_G1;
            6:       byte_o = addr_i[15:8];
            7:       byte_o = addr_i[7:0];
            8:       byte_o = B_HDR_GEN;
            9:       byte_o = B_HDR_G2;
            10:      byte_o = op_i;
            11:      byte_o = addr_i[23:16];
            12:      byte_o = B_HDR_CMD;
            13:      byte_o = B_HDR_CMDL;
            14:      byte_o = B_ZERO;
            15:      byte_o = B_REBOOT;
            16, 18:  byte_o = B_NOOP;
            default: byte_o = B_ZERO;
        endcase
    end

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import cfg_reboot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] op_i,
    input  logic              ready_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic [BYTE_W-1:0] cap_op_o,
    output logic              wr_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

    seq_state_t state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] op_q;
    logic              accept;
    logic              last_byte;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign last_byte = (idx_q == LAST_IDX);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_WAIT;
            ST_WAIT:   if (ready_i) state_d = ST_STROBE;
            ST_STROBE: state_d = last_byte ? ST_DONE : ST_WAIT;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Byte index: cleared on accept, stepped after each strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (accept) begin
            idx_q <= '0;
        end else if (state_q == ST_STROBE && !last_byte) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Address and opcode capture on the accepted start only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            op_q   <= '0;
        end else if (accept) begin
            addr_q <= addr_i;
            op_q   <= op_i;
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        wr_o   = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_WAIT:   busy_o = 1'b1;
            ST_STROBE: begin
                busy_o = 1'b1;
                wr_o   = 1'b1;
            end
            ST_DONE:   done_o = 1'b1;
            default:   ;
        endcase
    end

    assign idx_o      = idx_q;
    assign cap_addr_o = addr_q;
    assign cap_op_o   = op_q;

endmodule

// File: rtl/cfg_reboot_seq.sv
module cfg_reboot_seq
    import cfg_reboot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] flash_addr_i,
    input  logic [BYTE_W-1:0] read_op_i,
    input  logic              port_ready_i,
    output logic [BYTE_W-1:0] port_data_o,
    output logic              port_wr_o,
    output logic              busy_o,
    output logic              done_o
);

    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] cap_addr;
    logic [BYTE_W-1:0] cap_op;
    logic [BYTE_W-1:0] raw_byte;

    cfg_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .addr_i     (flash_addr_i),
        .op_i       (read_op_i),
        .ready_i    (port_ready_i),
        .idx_o      (idx),
        .cap_addr_o (cap_addr),
        .cap_op_o   (cap_op),
        .wr_o       (port_wr_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    cfg_pkt_rom u_rom (
        .idx_i  (idx),
        .addr_i (cap_addr),
        .op_i   (cap_op),
        .byte_o (raw_byte)
    );

    cfg_bit_mirror #(.W(BYTE_W)) u_mirror (
        .din  (raw_byte),
        .dout (port_data_o)
    );

endmodule

// File: rtl/cfg_reboot_chk.sv
module cfg_reboot_chk
    import cfg_reboot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              port_ready_i,
    input  logic              port_wr_o,
    input  logic              busy_o,
    input  logic              done_o,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [BYTE_W-1:0] cap_op
);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> busy_o);

    p_wr_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr_o |=> !port_wr_o);

    p_wr_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr_o |-> busy_o);

    p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr_o |-> $past(port_ready_i));

    p_hold_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(cap_addr) && $stable(cap_op)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_done_after_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(port_wr_o));

endmodule

bind cfg_reboot_seq cfg_reboot_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .port_ready_i (port_ready_i),
    .port_wr_o    (port_wr_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .cap_addr     (cap_addr),
    .cap_op       (cap_op)
);

// File: tb/cfg_reboot_seq_tb.sv
module cfg_reboot_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] flash_addr_i = '0;
    logic [7:0]  read_op_i = '0;
    logic        port_ready_i = 1'b0;
    logic [7:0]  port_data_o;
    logic        port_wr_o;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] cap [0:63];
    int ncap;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_reboot_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .flash_addr_i (flash_addr_i),
        .read_op_i    (read_op_i),
        .port_ready_i (port_ready_i),
        .port_data_o  (port_data_o),
        .port_wr_o    (port_wr_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Expected unmirrored byte at a packet position (R4, R5)
    function automatic logic [7:0] exp_raw(input int i, input logic [23:0] a, input logic [7:0] op);
        case (i)
            0, 1:   return 8'hFF;
            2:      return 8'hAA;
            3:      return 8'h99;
            4, 8:   return 8'h32;
            5:      return 8'h61;
            6:      return a[15:8];
            7:      return a[7:0];
            9:      return 8'h81;
            10:     return op;
            11:     return a[23:16];
            12:     return 8'h30;
            13:     return 8'hA1;
            15:     return 8'h0E;
            16, 18: return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    // Bit reversal per R6
    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = b[7-k];
        return r;
    endfunction

    // One full sequence. stall: ready pattern; hold: cycles of ready low
    // after start; scramble: change inputs after start; restart: extra start mid-run.
    task automatic run_seq(input logic [23:0] a, input logic [7:0] op, input bit stall,
                           input int hold, input bit scramble, input bit restart,
                           input string req);
        int ndone = 0;
        bit finished = 0;
        ncap = 0;
        @(negedge clk);
        port_ready_i = 1'b0;
        start_i = 1'b1;
        flash_addr_i = a;
        read_op_i = op;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
        if (scramble) begin
            flash_addr_i = ~a;
            read_op_i = ~op;
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(port_wr_o === 1'b0 && busy_o === 1'b1, "R7 hold while not ready",
                  int'({port_wr_o, busy_o}), 1);
        end
        for (int k = 0; k < 400 && !finished; k++) begin
            port_ready_i = stall ? ((k % 3) == 1) : 1'b1;
            if (restart) begin
                start_i = (k == 4);
                flash_addr_i = (k == 4) ? 24'h5A5A5A : a;
                read_op_i = (k == 4) ? 8'hC3 : op;
            end
            @(negedge clk);
            if (port_wr_o && ncap < 64) begin
                cap[ncap] = port_data_o;
                ncap++;
            end
            if (done_o) begin
                ndone++;
                finished = 1;
                check(busy_o === 1'b0, "R10 busy low with done", int'(busy_o), 0);
            end
        end
        start_i = 1'b0;
        port_ready_i = 1'b0;
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0 && port_wr_o === 1'b0,
              "R10 done one cycle then idle", int'({done_o, busy_o, port_wr_o}), 0);
        if (done_o) ndone++;
        check(ndone == 1, {req, " R9 single done"}, ndone, 1);
        check(ncap == 20, {req, " R3 byte count"}, ncap, 20);
        for (int i = 0; i < 20 && i < ncap; i++) begin
            logic [7:0] e;
            e = rev8(exp_raw(i, a, op));
            check(cap[i] === e, $sformatf("%s R4 R5 R6 byte %0d", req, i), int'(cap[i]), int'(e));
        end
    endtask

    task automatic t_reset();
        check(port_wr_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
              "R1 reset state", int'({port_wr_o, busy_o, done_o}), 0);
    endtask

    task automatic t_basic();
        run_seq(24'h0A_BC_DE, 8'h03, 1'b0, 0, 1'b0, 1'b0, "basic");
    endtask

    task automatic t_stall();
        run_seq(24'h81_42_18, 8'h0B, 1'b1, 0, 1'b0, 1'b0, "R7 stall");
    endtask

    task automatic t_ready_hold();
        run_seq(24'hF0_0F_C3, 8'h6B, 1'b0, 8, 1'b0, 1'b0, "R7 hold");
    endtask

    task automatic t_scramble();
        run_seq(24'h12_34_56, 8'h03, 1'b1, 2, 1'b1, 1'b0, "R8 capture");
    endtask

    task automatic t_restart();
        run_seq(24'hE7_01_80, 8'h13, 1'b0, 0, 1'b0, 1'b1, "R9 restart");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_stall();
        t_ready_hold();
        t_scramble();
        t_restart();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule